// File: doc/BRIEF.md
# Converter Bring-Up and Power Sequencer

This block is the host-side controller for a four-channel current/voltage output converter that is configured through 24-bit serial control writes. When reset is released it checks the static configuration on its inputs. It then sends a fixed series of control frames: the boost-converter setup word first, then one slew word per channel in channel order, then one output-control word per channel. When the series is complete it raises a done flag that stays high.

After bring-up the block watches one power-down request bit per channel. Every channel starts in the powered-down state. Clearing a request bit powers its channel up in two frames: the first turns on the channel's internal enable and boost enable, and the second, sent after a timed settling gap of 200 µs counted in system clocks, turns on the output. Setting a request bit powers the channel down in one frame that clears all three enables. The block keeps a copy of each channel's output-control word, so every frame carries the full word. A request that matches the channel's present state causes no traffic. Out-of-range configuration codes stop the block before it sends anything and raise an error flag.

Top module: `dac_bringup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select is high, the serial clock is low, and the done and error flags are low.
- R2: Each frame holds chip select low for exactly 24 serial clocks and is sent MSB first. The serial clock idles low and the receiver samples data on its rising edge. Frame bits 23:21 are 0 and bits 20:16 are 5'b111cc with cc the channel. Bits 15:13 select the sub-register: 0 for slew, 2 for output control, 3 for boost. Bits 12:0 carry the value.
- R3: The first frame after reset is the boost word on channel 0. Its value has the maximum-voltage code at bits 1:0, the frequency code at bits 3:2, the phase code at bits 5:4 and the external-compensation select at bit 6.
- R4: The next four frames are slew words for channels 0, 1, 2 and 3 in that order. Each value has the step code at bits 2:0, the rate code at bits 6:3 and the slew enable at bit 12.
- R5: The next four frames are output-control words for channels 0 to 3 in order. Each value has bit 5 set when the channel's sense resistor is internal (external-sense input low), bit 3 set for overrange, and the 3-bit mode at bits 2:0; after the last of them the done flag rises and stays high until reset.
- R6: If the frequency code is 3 or any channel mode is 7, no frame is ever sent, the error flag goes high and the done flag stays low.
- R7: All channels start powered down, so request bits that are all 1 after bring-up cause no traffic.
- R8: Clearing a channel's request bit sends its output-control word with bits 8 and 4 also set. A second frame follows that also has bit 6 set. Chip select stays high for at least 200 µs worth of system clocks between the two frames.
- R9: Setting the request bit of a powered-up channel sends one output-control frame with bits 8, 6 and 4 cleared and every other bit unchanged.
- R10: A request equal to the channel's present power state sends nothing.
- R11: Between consecutive frames chip select is high for at least one serial clock period.
- R12: When several channels have pending requests, they are served one at a time, lowest channel index first, and each power-up completes both of its frames before the next channel starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| dcMaxV | input | 2 | Boost maximum-voltage code |
| dcFreq | input | 2 | Boost switching-frequency code (0 to 2) |
| dcPhase | input | 2 | Boost phase-arrangement code |
| dcExtComp | input | 1 | Boost external compensation select |
| chMode | input | 12 | Output mode per channel, channel i at bits 3i+2:3i (0 to 6) |
| chExtSense | input | 4 | Per channel: external sense resistor in use |
| chOverrange | input | 4 | Per channel: overrange enable |
| slewEn | input | 4 | Per channel: digital slew enable |
| slewRate | input | 16 | Slew rate code per channel, channel i at bits 4i+3:4i |
| slewStep | input | 12 | Slew step code per channel, channel i at bits 3i+2:3i |
| pdReq | input | 4 | Per channel: 1 requests powered down, 0 requests powered up |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data out |
| cfgDone | output | 1 | Bring-up series complete |
| cfgError | output | 1 | Configuration rejected |

## Verification
The assertions assume that the configuration inputs hold still from reset release until the done flag rises, because the boost and slew frames read them while the series runs. The stimulus changes configuration only while reset is held, and it changes the request bits only after bring-up. The assertions also assume that the serial engine is started only when idle, which the controller guarantees and the bench never bypasses. Frames are checked by a bench-side receiver that samples data on rising serial clock edges, compares every field against values built from the requirements, and times the chip-select high intervals in system clocks.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  localparam int FRAME_W = 24;
  localparam int VAL_W   = 13;
  localparam int NUM_CH  = 4;   // fixed by the 2-bit channel field of a frame
  localparam int CH_W    = 2;

  // sub-register selects carried in frame bits 15:13
  localparam logic [2:0] SUB_SLEW = 3'd0;
  localparam logic [2:0] SUB_DAC  = 3'd2;
  localparam logic [2:0] SUB_DCDC = 3'd3;

  // output-control enable bits
  localparam logic [VAL_W-1:0] M_INT_EN  = 13'h100;
  localparam logic [VAL_W-1:0] M_OUT_EN  = 13'h040;
  localparam logic [VAL_W-1:0] M_DCDC_EN = 13'h010;

  typedef struct packed {
    logic               start;
    logic [FRAME_W-1:0] frame;
  } spi_cmd_t;

  function automatic logic [FRAME_W-1:0] ctrlFrame(input logic [CH_W-1:0] ch,
                                                   input logic [2:0] sub,
                                                   input logic [VAL_W-1:0] val);
    return {3'b000, 3'b111, ch, sub, val};
  endfunction

endpackage

// File: rtl/dacseq_spi.sv
module dacseq_spi
  import dacseq_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  spi_cmd_t cmd,
  output logic     frameDone,
  output logic     spiSclk,
  output logic     spiCsN,
  output logic     spiMosi
);

  localparam int DIV_W = $clog2(2 * SCLK_HALF + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {P_IDLE, P_SHIFT, P_GAP} pstate_t;

  pstate_t            state;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] shReg;

  assign spiMosi = shReg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= P_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      shReg     <= '0;
      spiSclk   <= 1'b0;
      spiCsN    <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        P_IDLE: begin
          if (cmd.start) begin
            shReg  <= cmd.frame;
            spiCsN <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            state  <= P_SHIFT;
          end
        end
        P_SHIFT: begin
          if (divCnt == DIV_W'(SCLK_HALF - 1)) begin
            divCnt <= '0;
            if (!spiSclk) begin
              spiSclk <= 1'b1;
            end else begin
              spiSclk <= 1'b0;
              if (bitCnt == BIT_W'(FRAME_W - 1)) begin
                spiCsN <= 1'b1;
                state  <= P_GAP;
              end else begin
                bitCnt <= bitCnt + 1'b1;
                shReg  <= {shReg[FRAME_W-2:0], 1'b0};
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: begin
          if (divCnt == DIV_W'(2 * SCLK_HALF - 1)) begin
            divCnt    <= '0;
            state     <= P_IDLE;
            frameDone <= 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // checker state: how long chip select has been high, saturating
  logic [15:0] csHighRun;
  always_ff @(posedge clk) begin
    if (!rstN)                csHighRun <= '1;
    else if (!spiCsN)         csHighRun <= '0;
    else if (csHighRun != '1) csHighRun <= csHighRun + 1'b1;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);  // R2
  AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> ($past(csHighRun) >= 16'(2 * SCLK_HALF)));  // R11
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> (state == P_IDLE));  // R2

endmodule

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int WAIT_CYC = 20000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            dcMaxV,
  input  logic [1:0]            dcFreq,
  input  logic [1:0]            dcPhase,
  input  logic                  dcExtComp,
  input  logic [3*NUM_CH-1:0]   chMode,
  input  logic [NUM_CH-1:0]     chExtSense,
  input  logic [NUM_CH-1:0]     chOverrange,
  input  logic [NUM_CH-1:0]     slewEn,
  input  logic [4*NUM_CH-1:0]   slewRate,
  input  logic [3*NUM_CH-1:0]   slewStep,
  input  logic [NUM_CH-1:0]     pdReq,
  input  logic                  frameDone,
  output spi_cmd_t              cmd,
  output logic                  cfgDone,
  output logic                  cfgError
);

  localparam int LAST_STEP = 2 * NUM_CH;
  localparam int STEP_W    = $clog2(LAST_STEP + 1);
  localparam int GAP_W     = $clog2(WAIT_CYC + 1);

  typedef enum logic [2:0] {
    C_CHECK, C_CFG_ISSUE, C_CFG_WAIT, C_RUN,
    C_PWR_ISSUE, C_PWR_WAIT, C_GAP, C_FAULT
  } cstate_t;

  cstate_t              state;
  logic [STEP_W-1:0]    step;
  logic [CH_W-1:0]      chSel;
  logic                 upPhase1;
  logic [GAP_W-1:0]     gapCnt;
  logic [NUM_CH-1:0]    pwrDown;
  logic [VAL_W-1:0]     shadow [NUM_CH];

  // configuration code check
  logic cfgBad;
  always_comb begin
    cfgBad = (dcFreq == 2'd3);
    for (int i = 0; i < NUM_CH; i++)
      if (chMode[3*i +: 3] == 3'd7) cfgBad = 1'b1;
  end

  // lowest-index channel whose request differs from its state
  logic            found;
  logic [CH_W-1:0] pick;
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pdReq[i] != pwrDown[i]) begin
        found = 1'b1;
        pick  = CH_W'(i);
      end
  end

  // frame selection
  logic [CH_W-1:0]    cfgCh;
  logic [FRAME_W-1:0] frameSel;
  always_comb begin
    cfgCh    = '0;
    frameSel = '0;
    if (state == C_PWR_ISSUE) begin
      frameSel = ctrlFrame(chSel, SUB_DAC, shadow[chSel]);
    end else if (step == '0) begin
      frameSel = ctrlFrame('0, SUB_DCDC,
                           {6'b0, dcExtComp, dcPhase, dcFreq, dcMaxV});
    end else if (step <= STEP_W'(NUM_CH)) begin
      cfgCh    = CH_W'(step - 1'b1);
      frameSel = ctrlFrame(cfgCh, SUB_SLEW,
                           {slewEn[cfgCh], 5'b0, slewRate[cfgCh*4 +: 4],
                            slewStep[cfgCh*3 +: 3]});
    end else begin
      cfgCh    = CH_W'(step - STEP_W'(NUM_CH + 1));
      frameSel = ctrlFrame(cfgCh, SUB_DAC, shadow[cfgCh]);
    end
  end

  assign cmd.start = (state == C_CFG_ISSUE) || (state == C_PWR_ISSUE);
  assign cmd.frame = frameSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= C_CHECK;
      step     <= '0;
      chSel    <= '0;
      upPhase1 <= 1'b0;
      gapCnt   <= '0;
      pwrDown  <= '1;
      cfgDone  <= 1'b0;
      cfgError <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) shadow[i] <= '0;
    end else begin
      case (state)
        C_CHECK: begin
          for (int i = 0; i < NUM_CH; i++)
            shadow[i] <= {7'b0, ~chExtSense[i], 1'b0, chOverrange[i], chMode[3*i +: 3]};
          step <= '0;
          if (cfgBad) begin
            cfgError <= 1'b1;
            state    <= C_FAULT;
          end else begin
            state <= C_CFG_ISSUE;
          end
        end
        C_CFG_ISSUE: state <= C_CFG_WAIT;
        C_CFG_WAIT: begin
          if (frameDone) begin
            if (step == STEP_W'(LAST_STEP)) begin
              cfgDone <= 1'b1;
              state   <= C_RUN;
            end else begin
              step  <= step + 1'b1;
              state <= C_CFG_ISSUE;
            end
          end
        end
        C_RUN: begin
          if (found) begin
            chSel <= pick;
            state <= C_PWR_ISSUE;
            if (!pdReq[pick]) begin
              shadow[pick]  <= shadow[pick] | M_INT_EN | M_DCDC_EN;
              pwrDown[pick] <= 1'b0;
              upPhase1      <= 1'b1;
            end else begin
              shadow[pick]  <= shadow[pick] & ~(M_INT_EN | M_OUT_EN | M_DCDC_EN);
              pwrDown[pick] <= 1'b1;
              upPhase1      <= 1'b0;
            end
          end
        end
        C_PWR_ISSUE: state <= C_PWR_WAIT;
        C_PWR_WAIT: begin
          if (frameDone) begin
            gapCnt <= '0;
            state  <= upPhase1 ? C_GAP : C_RUN;
          end
        end
        C_GAP: begin
          if (gapCnt == GAP_W'(WAIT_CYC - 1)) begin
            shadow[chSel] <= shadow[chSel] | M_OUT_EN;
            upPhase1      <= 1'b0;
            state         <= C_PWR_ISSUE;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= C_FAULT;
      endcase
    end
  end

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> cfgDone);  // R5
  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!cmd.start && !cfgDone));  // R6
  AST_ONE_CHANNEL_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pwrDown ^ $past(pwrDown)) <= 1);  // R12
  AST_POWER_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_PWR_ISSUE) |-> cfgDone);  // R7

endmodule

// File: rtl/dac_bringup_seq.sv
module dac_bringup_seq
  import dacseq_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int SCLK_HALF  = 2,
  parameter int UP_WAIT_US = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  dcMaxV,
  input  logic [1:0]  dcFreq,
  input  logic [1:0]  dcPhase,
  input  logic        dcExtComp,
  input  logic [11:0] chMode,
  input  logic [3:0]  chExtSense,
  input  logic [3:0]  chOverrange,
  input  logic [3:0]  slewEn,
  input  logic [15:0] slewRate,
  input  logic [11:0] slewStep,
  input  logic [3:0]  pdReq,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  output logic        cfgDone,
  output logic        cfgError
);

  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * UP_WAIT_US;

  spi_cmd_t cmd;
  logic     frameDone;

  dacseq_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .dcMaxV(dcMaxV), .dcFreq(dcFreq), .dcPhase(dcPhase), .dcExtComp(dcExtComp),
    .chMode(chMode), .chExtSense(chExtSense), .chOverrange(chOverrange),
    .slewEn(slewEn), .slewRate(slewRate), .slewStep(slewStep),
    .pdReq(pdReq), .frameDone(frameDone), .cmd(cmd),
    .cfgDone(cfgDone), .cfgError(cfgError)
  );

  dacseq_spi #(.SCLK_HALF(SCLK_HALF)) u_spi (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameDone(frameDone),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi)
  );

endmodule

// File: tb/sim_dac_bringup_seq.sv
`timescale 1ns/1ps
module sim_dac_bringup_seq;

  localparam int WAIT_EXP = 2000;  // 10 MHz count base x 200 us
  localparam int MIN_GAP  = 4;     // one serial period with half period 2

  typedef struct packed {
    logic [1:0]  maxv;
    logic [1:0]  freq;
    logic [1:0]  phase;
    logic        ext;
    logic [11:0] mode;
    logic [3:0]  sense;
    logic [3:0]  ovr;
    logic [3:0]  sen;
    logic [15:0] rate;
    logic [11:0] stp;
  } cfg_t;

  localparam cfg_t CFGS [3] = '{
    '{2'd2, 2'd1, 2'd3, 1'b1, {3'd4, 3'd6, 3'd0, 3'd5}, 4'b0101, 4'b1010, 4'b0011,
      16'hF810, {3'd7, 3'd0, 3'd3, 3'd1}},
    '{2'd0, 2'd0, 2'd0, 1'b0, {3'd0, 3'd1, 3'd2, 3'd3}, 4'hF, 4'h0, 4'hF,
      16'h1234, {3'd2, 3'd4, 3'd6, 3'd5}},
    '{2'd3, 2'd2, 2'd1, 1'b0, {3'd6, 3'd6, 3'd6, 3'd6}, 4'h0, 4'hF, 4'h0,
      16'hABCD, 12'h000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] dcMaxV = '0, dcFreq = '0, dcPhase = '0;
  logic dcExtComp = 1'b0;
  logic [11:0] chMode = '0, slewStep = '0;
  logic [3:0] chExtSense = '0, chOverrange = '0, slewEn = '0, pdReq = 4'hF;
  logic [15:0] slewRate = '0;
  logic spiSclk, spiCsN, spiMosi, cfgDone, cfgError;

  always #5 clk = ~clk;

  dac_bringup_seq #(.CLK_HZ(10_000_000)) u0 (
    .clk(clk), .rstN(rstN), .dcMaxV(dcMaxV), .dcFreq(dcFreq), .dcPhase(dcPhase),
    .dcExtComp(dcExtComp), .chMode(chMode), .chExtSense(chExtSense),
    .chOverrange(chOverrange), .slewEn(slewEn), .slewRate(slewRate),
    .slewStep(slewStep), .pdReq(pdReq), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .cfgDone(cfgDone), .cfgError(cfgError)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // receiver: samples away from the active clock edge
  logic [23:0] capF [128];
  int capStart [128];
  int capEnd [128];
  int capBits [128];
  int nCap = 0;
  int cyc = 0;
  logic [23:0] rxSh = '0;
  int rxBits = 0;
  logic pS = 1'b0, pC = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (pC && !spiCsN) begin
      rxSh = '0;
      rxBits = 0;
      capStart[nCap] = cyc;
    end
    if (!spiCsN && !pS && spiSclk) begin
      rxSh = {rxSh[22:0], spiMosi};
      rxBits++;
    end
    if (!pC && spiCsN) begin
      capF[nCap] = rxSh;
      capEnd[nCap] = cyc;
      capBits[nCap] = rxBits;
      if (nCap < 127) nCap++;
    end
    pS = spiSclk;
    pC = spiCsN;
  end

  function automatic logic [23:0] mkF(input int ch, input logic [2:0] sub,
                                      input logic [12:0] val);
    logic [1:0] c = 2'(ch);
    return {6'b000111, c, sub, val};
  endfunction

  function automatic logic [12:0] baseWord(input cfg_t c, input int ch);
    return {7'b0, ~c.sense[ch], 1'b0, c.ovr[ch], c.mode[3*ch +: 3]};
  endfunction

  function automatic logic [23:0] expCfg(input cfg_t c, input int idx);
    if (idx == 0)
      return mkF(0, 3'd3, {6'b0, c.ext, c.phase, c.freq, c.maxv});
    else if (idx <= 4)
      return mkF(idx - 1, 3'd0, {c.sen[idx-1], 5'b0, c.rate[4*(idx-1) +: 4],
                                 c.stp[3*(idx-1) +: 3]});
    else
      return mkF(idx - 5, 3'd2, baseWord(c, idx - 5));
  endfunction

  task automatic applyAndReset(input cfg_t c);
    @(negedge clk);
    rstN = 1'b0;
    dcMaxV = c.maxv; dcFreq = c.freq; dcPhase = c.phase; dcExtComp = c.ext;
    chMode = c.mode; chExtSense = c.sense; chOverrange = c.ovr;
    slewEn = c.sen; slewRate = c.rate; slewStep = c.stp;
    pdReq = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitFrames(input int target, input int limit);
    for (int k = 0; k < limit && nCap < target; k++) @(negedge clk);
  endtask

  initial begin
    int base;
    int b1;
    cfg_t c;
    // reset state (R1)
    repeat (3) @(negedge clk);
    chk(spiCsN === 1'b1 && spiSclk === 1'b0, "R1 lines in reset", {spiCsN, spiSclk}, 2'b10);
    chk(cfgDone === 1'b0 && cfgError === 1'b0, "R1 flags in reset", {cfgDone, cfgError}, 2'b00);

    // table of configurations walked by one loop (R2..R5, R11)
    for (int v = 0; v < 3; v++) begin
      c = CFGS[v];
      base = nCap;
      applyAndReset(c);
      @(negedge clk);
      chk(spiCsN === 1'b1 && cfgDone === 1'b0, "R1 first cycle after reset",
          {spiCsN, cfgDone}, 2'b10);
      for (int k = 0; k < 3000 && !cfgDone; k++) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(nCap - base == 9, "R5 frame count", nCap - base, 9);
      chk(cfgDone === 1'b1 && cfgError === 1'b0, "R5 done flag", {cfgDone, cfgError}, 2'b10);
      for (int f = 0; f < 9; f++) begin
        chk(capF[base+f] == expCfg(c, f),
            f == 0 ? "R3 boost frame" : (f <= 4 ? "R4 slew frame" : "R5 control frame"),
            capF[base+f], expCfg(c, f));
        chk(capBits[base+f] == 24, "R2 clocks per frame", capBits[base+f], 24);
        if (f > 0)
          chk(capStart[base+f] - capEnd[base+f-1] >= MIN_GAP, "R11 chip-select gap",
              capStart[base+f] - capEnd[base+f-1], MIN_GAP);
      end
    end

    // invalid frequency code (R6)
    c = CFGS[0];
    c.freq = 2'd3;
    base = nCap;
    applyAndReset(c);
    repeat (1500) @(negedge clk);
    chk(nCap == base, "R6 no traffic on bad frequency", nCap - base, 0);
    chk(cfgError === 1'b1 && cfgDone === 1'b0, "R6 error flag", {cfgError, cfgDone}, 2'b10);

    // invalid mode on channel 2 (R6)
    c = CFGS[1];
    c.mode[8:6] = 3'd7;
    base = nCap;
    applyAndReset(c);
    repeat (1500) @(negedge clk);
    chk(nCap == base, "R6 no traffic on bad mode", nCap - base, 0);
    chk(cfgError === 1'b1 && cfgDone === 1'b0, "R6 error flag mode", {cfgError, cfgDone}, 2'b10);

    // power sequencing on configuration 0
    c = CFGS[0];
    applyAndReset(c);
    for (int k = 0; k < 3000 && !cfgDone; k++) @(negedge clk);
    chk(cfgDone === 1'b1, "R5 done before power test", cfgDone, 1);
    base = nCap;
    repeat (500) @(negedge clk);
    chk(nCap == base, "R7 channels start powered down", nCap - base, 0);

    // power up channel 1 (R8)
    b1 = nCap;
    pdReq[1] = 1'b0;
    waitFrames(b1 + 2, 6000);
    repeat (20) @(negedge clk);
    chk(nCap - b1 == 2, "R8 two frames", nCap - b1, 2);
    chk(capF[b1] == mkF(1, 3'd2, baseWord(c, 1) | 13'h110), "R8 first power-up frame",
        capF[b1], mkF(1, 3'd2, baseWord(c, 1) | 13'h110));
    chk(capF[b1+1] == mkF(1, 3'd2, baseWord(c, 1) | 13'h150), "R8 second power-up frame",
        capF[b1+1], mkF(1, 3'd2, baseWord(c, 1) | 13'h150));
    chk(capStart[b1+1] - capEnd[b1] >= WAIT_EXP, "R8 settling gap",
        capStart[b1+1] - capEnd[b1], WAIT_EXP);

    // power down channel 1 (R9)
    b1 = nCap;
    pdReq[1] = 1'b1;
    repeat (300) @(negedge clk);
    chk(nCap - b1 == 1, "R9 single frame", nCap - b1, 1);
    chk(capF[b1] == mkF(1, 3'd2, baseWord(c, 1) & ~13'h150), "R9 power-down frame",
        capF[b1], mkF(1, 3'd2, baseWord(c, 1) & ~13'h150));

    // matching request (R10)
    b1 = nCap;
    pdReq = 4'hF;
    repeat (300) @(negedge clk);
    chk(nCap == b1, "R10 matching request silent", nCap - b1, 0);

    // two channels at once (R12)
    b1 = nCap;
    pdReq = 4'b1010;
    waitFrames(b1 + 4, 12000);
    repeat (20) @(negedge clk);
    chk(nCap - b1 == 4, "R12 four frames", nCap - b1, 4);
    chk(capF[b1] == mkF(0, 3'd2, baseWord(c, 0) | 13'h110), "R12 ch0 first",
        capF[b1], mkF(0, 3'd2, baseWord(c, 0) | 13'h110));
    chk(capF[b1+1] == mkF(0, 3'd2, baseWord(c, 0) | 13'h150), "R12 ch0 second",
        capF[b1+1], mkF(0, 3'd2, baseWord(c, 0) | 13'h150));
    chk(capF[b1+2] == mkF(2, 3'd2, baseWord(c, 2) | 13'h110), "R12 ch2 first",
        capF[b1+2], mkF(2, 3'd2, baseWord(c, 2) | 13'h110));
    chk(capF[b1+3] == mkF(2, 3'd2, baseWord(c, 2) | 13'h150), "R12 ch2 second",
        capF[b1+3], mkF(2, 3'd2, baseWord(c, 2) | 13'h150));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule